// File: doc/BRIEF.md
# Multichannel ADC Read Sequencer

This block drives a sampling converter that has a parallel data bus and several input channels, from logic running on one clock. On a start request it pulls the convert-start line low for a fixed number of clocks. It then waits for the converter's end-of-conversion line to fall. After a guard time it issues one combined chip-select/read strobe for each channel. The converter itself does not say which channel it is returning. The result order is fixed: the first read after a conversion returns channel 0, and each later read returns the next channel. The sequencer counts its own reads to label each captured word.

Every captured word leaves the block with its channel index and a valid pulse one clock wide. The end-of-conversion input is asynchronous, so it passes through a two-flop synchronizer before use. If it never falls, a timeout ends the attempt and raises a sticky error flag. Each pulse width is a parameter in clock cycles. The defaults are sized for a 4 ns clock.

Top module: `adc_rdseq`

## Requirements
- R1: While reset is held and right after it, convst_n_o, cs_n_o and rd_n_o are high, smp_valid_o is low and tmo_err_o is low.
- R2: A start_i sampled high while the block is idle drives convst_n_o low for exactly CONV_CLK clock cycles (default 3).
- R3: No read strobe occurs during a conversion. The first falling edge of rd_n_o after a conversion comes only after eoc_n_i has fallen, and at least EOC_GAP_CLK clocks (default 15, which is 60 ns at 4 ns) after that fall.
- R4: cs_n_o equals rd_n_o on every cycle. Each read holds them low for exactly RD_LO_CLK cycles (default 4).
- R5: Between two reads of the same conversion, rd_n_o stays high for exactly RD_HI_CLK cycles (default 3).
- R6: Every conversion that completes produces exactly NCH reads (default 4). They are tagged on smp_chan_o with indices 0, 1, ..., NCH-1 in that order. Index 0 is the first read after the conversion, which is the converter's first channel.
- R7: smp_data_o holds the value that adc_data_i carried in the last clock of the read strobe. smp_valid_o is high for one cycle only: the cycle in which rd_n_o has just returned high.
- R8: A start_i that arrives while a conversion or its reads are in progress is ignored. No further convst_n_o pulse starts until all NCH reads are done and a new start_i is seen while idle.
- R9: If eoc_n_i does not fall within TMO_CLK cycles (default 1000) after convst_n_o rises, tmo_err_o goes high exactly TMO_CLK cycles after that rise. No read follows, and the block returns to idle. The next accepted start clears tmo_err_o in the same cycle that convst_n_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and read-out; acted on only while idle |
| eoc_n_i | input | 1 | End-of-conversion from the converter, asynchronous, low when done |
| adc_data_i | input | DW | Converter data bus |
| convst_n_o | output | 1 | Convert start, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| smp_valid_o | output | 1 | One-cycle pulse marking a captured sample |
| smp_chan_o | output | clog2(NCH) | Channel index of the sample |
| smp_data_o | output | DW | Captured sample |
| tmo_err_o | output | 1 | Sticky conversion-timeout flag |

## Verification
Each result is due a fixed number of clocks after its cause. The convert-start pulse lasts CONV_CLK cycles from the clock that accepts start. Each read strobe lasts RD_LO_CLK cycles, and the gap between strobes lasts RD_HI_CLK cycles. The valid pulse lands in the same cycle that the read strobe rises. The timeout flag rises TMO_CLK cycles after convert-start goes high, and the next accepted start clears it in the cycle that convert-start falls. The bench samples on the falling clock edge and counts these windows in sampled cycles. It checks the converter-side 60 ns gap in absolute time, taken from a behavioural converter model whose pointer and end-of-conversion rules decide the expected channel and data of every sample.

// File: rtl/adc_rdseq_pkg.sv
`timescale 1ns/1ps
package adc_rdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_GUARD = 3'd3,
    ST_RDLO  = 3'd4,
    ST_RDHI  = 3'd5
  } seq_state_t;

  // Guard clocks after the synchronized edge. The synchronizer already adds
  // at least two clocks, so gap-1 keeps a margin over the requested gap.
  function automatic int guard_len(int gap_clk);
    return (gap_clk > 1) ? gap_clk - 1 : 1;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rdseq_sync.sv
`timescale 1ns/1ps
module adc_rdseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-clock delay
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], async_i};
  end

  assign sync_o = sh[STAGES-1];
  assign fall_o = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/adc_rdseq_timer.sv
`timescale 1ns/1ps
module adc_rdseq_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  // R4/R5 support: a loaded segment counts down and never wraps
  a_r4_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && $past(cnt_q) == '0 && $past(!load_i)) |-> cnt_q == '0);

endmodule

// File: rtl/adc_rdseq_capture.sv
`timescale 1ns/1ps
module adc_rdseq_capture #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic [DW-1:0] data_i,
  output logic          last_o,
  output logic          valid_o,
  output logic [CW-1:0] chan_o,
  output logic [DW-1:0] data_o
);
  logic [CW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      valid_o <= 1'b0;
      chan_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= take_i;
      if (clr_i) begin
        ptr_q <= '0;
      end else if (take_i) begin
        ptr_q  <= ptr_q + 1'b1;
        chan_o <= ptr_q;
        data_o <= data_i;
      end
    end
  end

  assign last_o = (ptr_q == CW'(NCH - 1));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r6_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(chan_o) < NCH));

endmodule

// File: rtl/adc_rdseq.sv
`timescale 1ns/1ps
module adc_rdseq
  import adc_rdseq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 12,
  parameter int CONV_CLK    = 3,
  parameter int EOC_GAP_CLK = 15,
  parameter int RD_LO_CLK   = 4,
  parameter int RD_HI_CLK   = 3,
  parameter int TMO_CLK     = 1000,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          eoc_n_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          convst_n_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic          smp_valid_o,
  output logic [CW-1:0] smp_chan_o,
  output logic [DW-1:0] smp_data_o,
  output logic          tmo_err_o
);
  localparam int GUARD_CLK = guard_len(EOC_GAP_CLK);
  localparam int LEN_MAX   = max_of(max_of(CONV_CLK, TMO_CLK),
                                    max_of(GUARD_CLK, max_of(RD_LO_CLK, RD_HI_CLK)));
  localparam int CNT_W     = $clog2(LEN_MAX + 1);

  seq_state_t       st_q, st_d;
  logic             eoc_sync, eoc_fall;
  logic             seg_last, seg_load;
  logic [CNT_W-1:0] seg_val;
  logic             last_chan, take, clr, tmo_fire;

  // Segment length minus one, for the segment that starts in a state
  function automatic logic [CNT_W-1:0] seg_len(seq_state_t s);
    case (s)
      ST_CONV:  return CNT_W'(CONV_CLK - 1);
      ST_WAIT:  return CNT_W'(TMO_CLK - 1);
      ST_GUARD: return CNT_W'(GUARD_CLK - 1);
      ST_RDLO:  return CNT_W'(RD_LO_CLK - 1);
      ST_RDHI:  return CNT_W'(RD_HI_CLK - 1);
      default:  return '0;
    endcase
  endfunction

  adc_rdseq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(eoc_n_i),
    .sync_o(eoc_sync), .fall_o(eoc_fall)
  );

  adc_rdseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(seg_load),
    .load_val_i(seg_val), .last_o(seg_last)
  );

  adc_rdseq_capture #(.NCH(NCH), .DW(DW), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .take_i(take),
    .data_i(adc_data_i), .last_o(last_chan),
    .valid_o(smp_valid_o), .chan_o(smp_chan_o), .data_o(smp_data_o)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_i)  st_d = ST_CONV;
      ST_CONV:  if (seg_last) st_d = ST_WAIT;
      ST_WAIT:  if (eoc_fall) st_d = ST_GUARD;
                else if (seg_last) st_d = ST_IDLE;
      ST_GUARD: if (seg_last) st_d = ST_RDLO;
      ST_RDLO:  if (seg_last) st_d = last_chan ? ST_IDLE : ST_RDHI;
      ST_RDHI:  if (seg_last) st_d = ST_RDLO;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign seg_load = (st_d != st_q);
  assign seg_val  = seg_len(st_d);
  assign clr      = (st_q == ST_IDLE) && start_i;
  assign take     = (st_q == ST_RDLO) && seg_last;
  assign tmo_fire = (st_q == ST_WAIT) && seg_last && !eoc_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tmo_err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clr)           tmo_err_o <= 1'b0;
      else if (tmo_fire) tmo_err_o <= 1'b1;
    end
  end

  assign convst_n_o = (st_q != ST_CONV);
  assign rd_n_o     = (st_q != ST_RDLO);
  assign cs_n_o     = (st_q != ST_RDLO);

  // ---------------- checker counters and assertions ----------------
  logic [7:0]       since_eoc;  // clocks the synchronized end-of-conversion has been low
  logic [CNT_W:0]   conv_len;   // clocks convst_n_o has been low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_eoc <= '0;
      conv_len  <= '0;
    end else begin
      if (eoc_sync)               since_eoc <= '0;
      else if (since_eoc != 8'hFF) since_eoc <= since_eoc + 1'b1;
      if (convst_n_o) conv_len <= '0;
      else            conv_len <= conv_len + 1'b1;
    end
  end

  a_r2_convst_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> (int'(conv_len) == CONV_CLK));

  a_r3_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_o) && $past(st_q) == ST_GUARD) |-> (int'(since_eoc) >= EOC_GAP_CLK));

  a_r7_valid_on_rd_rise: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $rose(rd_n_o));

  a_r9_no_read_after_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> rd_n_o);

endmodule

// File: tb/adc_rdseq_test.sv
`timescale 1ns/1ps
module adc_rdseq_test;
  localparam int NCH = 4, DW = 12, CONV_CLK = 3, RD_LO = 4, RD_HI = 3, TMO = 1000;
  localparam real GAP_NS = 60.0;
  localparam int CONV_NS = 201;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DW-1:0] adc_data = '0;
  logic eoc_n;
  logic convst_n, cs_n, rd_n, valid, err;
  logic [1:0] chan;
  logic [DW-1:0] sdata;

  always #2 clk = ~clk;

  adc_rdseq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .eoc_n_i(eoc_n), .adc_data_i(adc_data),
    .convst_n_o(convst_n), .cs_n_o(cs_n), .rd_n_o(rd_n), .smp_valid_o(valid),
    .smp_chan_o(chan), .smp_data_o(sdata), .tmo_err_o(err)
  );

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int c, int ch);
    return DW'((c * 613 + ch * 157 + 41) % 4096);
  endfunction

  // ---------------- behavioural converter ----------------
  int conv_id = 0, done_cnt = 0, clr_cnt = 0;
  int rd_falls = 0, rd_rises = 0, fall_base = 0, rise_base = 0;
  bit dead = 0;
  realtime t_eoc = 0;
  int qc[$], qd[$];

  assign eoc_n = (done_cnt == clr_cnt);

  always @(posedge convst_n) if (rst_n) begin
    conv_id++;
    fall_base = rd_falls;
    rise_base = rd_rises;
    if (!dead) begin
      #(CONV_NS);
      t_eoc = $realtime;
      done_cnt++;
    end
  end

  always @(negedge rd_n) if (rst_n) begin
    int p;
    p = rd_rises - rise_base;
    if (rd_falls == fall_base) begin
      chk(eoc_n == 1'b0, "R3 eoc low before first read", int'(eoc_n), 0);
      chk(($realtime - t_eoc) >= GAP_NS, "R3 eoc-to-read gap ns",
          int'($realtime - t_eoc), int'(GAP_NS));
      clr_cnt = done_cnt;
    end
    qc.push_back(p);
    qd.push_back(int'(pat(conv_id, p)));
    rd_falls++;
    #3 adc_data = pat(conv_id, p);
  end

  always @(posedge rd_n) if (rst_n) begin
    rd_rises++;
    #1 adc_data = 12'hA5A;
  end

  // ---------------- per-cycle monitor ----------------
  bit p_conv = 1, p_rd = 1, p_valid = 0, expect_clr = 0, mon_on = 0;
  int conv_lo = 0, rd_lo = 0, rd_hi = 0, reads_in_conv = 0;
  int conv_falls = 0, valids = 0;

  always @(negedge clk) if (mon_on) begin
    chk(cs_n == rd_n, "R4 cs equals rd", int'(cs_n), int'(rd_n));
    if (!convst_n) conv_lo++;
    if (convst_n && !p_conv) begin
      chk(conv_lo == CONV_CLK, "R2 convst low width", conv_lo, CONV_CLK);
      conv_lo = 0;
    end
    if (!convst_n && p_conv) begin
      conv_falls++;
      reads_in_conv = 0;
      if (expect_clr) begin
        chk(err == 1'b0, "R9 error cleared by start", int'(err), 0);
        expect_clr = 0;
      end
    end
    if (!rd_n && p_rd) begin
      if (reads_in_conv > 0) chk(rd_hi == RD_HI, "R5 read high gap", rd_hi, RD_HI);
      reads_in_conv++;
      rd_lo = 0;
    end
    if (!rd_n) rd_lo++;
    if (rd_n) rd_hi++;
    if (rd_n && !p_rd) begin
      chk(rd_lo == RD_LO, "R4 read low width", rd_lo, RD_LO);
      rd_hi = 1;
    end
    if (valid) begin
      int ec, ed;
      valids++;
      chk(rd_n && !p_rd, "R7 valid on rd rise", int'(rd_n), 1);
      chk(!p_valid, "R7 valid one clock", int'(p_valid), 0);
      if (qc.size() > 0) begin
        ec = qc.pop_front();
        ed = qd.pop_front();
        chk(int'(chan) == ec, "R6 channel order", int'(chan), ec);
        chk(int'(sdata) == ed, "R7 captured data", int'(sdata), ed);
      end else chk(0, "R6 sample without read", 1, 0);
    end
    p_conv = convst_n; p_rd = rd_n; p_valid = valid;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_valids(int target);
    for (int i = 0; i < 5000 && valids < target; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int good = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(convst_n && cs_n && rd_n && !valid && !err, "R1 reset outputs", int'({convst_n,cs_n,rd_n,valid,err}), 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(convst_n && cs_n && rd_n && !valid && !err, "R1 after reset", int'({convst_n,cs_n,rd_n,valid,err}), 5'b11100);
    mon_on = 1;

    // basic conversion
    pulse_start(); good++;
    wait_valids(NCH * good);
    chk(valids == NCH * good, "R6 reads per conversion", valids, NCH * good);

    // R8: extra starts while busy
    pulse_start(); good++;
    repeat (10) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 3000 && valids < NCH * (good - 1) + 1; i++) @(negedge clk);
    pulse_start();
    wait_valids(NCH * good);
    repeat (30) @(negedge clk);
    chk(conv_falls == good, "R8 busy start ignored", conv_falls, good);
    chk(valids == NCH * good, "R6 reads per conversion", valids, NCH * good);

    // several further conversions, different data
    for (int k = 0; k < 3; k++) begin
      pulse_start(); good++;
      wait_valids(NCH * good);
    end
    chk(valids == NCH * good, "R6 reads after loop", valids, NCH * good);

    // R9 timeout
    dead = 1;
    pulse_start();
    begin
      int n = 0, r0;
      r0 = rd_falls;
      for (int i = 0; i < 100 && convst_n !== 1'b0; i++) @(negedge clk);
      for (int i = 0; i < 100 && convst_n !== 1'b1; i++) @(negedge clk);
      while (!err && n < 3000) begin @(negedge clk); n++; end
      chk(n == TMO, "R9 timeout latency", n, TMO);
      repeat (50) @(negedge clk);
      chk(err == 1'b1, "R9 error sticky", int'(err), 1);
      chk(rd_falls == r0, "R9 no reads after timeout", rd_falls - r0, 0);
    end
    dead = 0;
    expect_clr = 1;
    pulse_start(); good++;
    wait_valids(NCH * good);
    chk(expect_clr == 0, "R9 clear observed", int'(expect_clr), 0);
    chk(valids == NCH * good, "R6 reads after timeout", valids, NCH * good);
    chk(qc.size() == 0, "R6 no unmatched reads", qc.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule